// File: doc/BRIEF.md
# Timer Clock Select with Prescaler

This block produces the count-enable pulse for an 8-bit timer/counter. A 3-bit select input picks one of eight sources: stopped, every system clock, one of four divided rates taken from a shared free-running prescaler, or a falling or rising edge on an external pin. The chosen source is turned into a single-cycle `count_tick` pulse. That pulse steps a small companion counter, which can be loaded directly.

The prescaler is a 10-bit counter that never stops. Each divided rate fires when the low bits of that counter return to zero. This keeps all taps phase-locked to one another. The external pin goes through a two-flop synchronizer and then an edge detector. Because only the pin's sampled level matters, a pin that the chip drives itself can step the count as well as one driven from outside. The select is sampled into the tick register, so a new select governs the tick from the next clock onward, with no half-period leftovers.

Top module: `tmr_clock_select`

## Requirements
- R1: Select 3'b000 produces no `count_tick`, and `count_q` holds its value.
- R2: Select 3'b001 produces `count_tick` on every cycle.
- R3: Selects 3'b010, 3'b011, 3'b100 and 3'b101 produce one `count_tick` every 8, 64, 256 and 1024 cycles. A tick is registered in the cycle after the free-running 10-bit prescaler (0 right after reset, +1 per cycle) has its low 3, 6, 8 or 10 bits all zero.
- R4: Select 3'b110 produces exactly one single-cycle tick per falling edge of `ext_pin`. The tick is high after the third rising clock edge that follows the first sampling of the new pin level.
- R5: Select 3'b111 does the same for each rising edge of `ext_pin`, with the same latency. Only the pin's level is used, so a locally driven pin steps the count.
- R6: A new select value governs `count_tick` from the first clock edge after it is applied. No tick derived from the previous select follows.
- R7: Each cycle with `count_tick` high advances `count_q` by one at the next clock edge, and 8'hFF wraps to 8'h00.
- R8: When `cnt_wr_en` is high, the next edge loads `cnt_wr_data` into `count_q`, taking priority over a pending tick.
- R9: Synchronous active-high `rst` clears `count_q`, `count_tick`, the prescaler phase and the pin synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Count source select |
| ext_pin | input | 1 | External count pin (asynchronous) |
| cnt_wr_en | input | 1 | Load strobe for the counter |
| cnt_wr_data | input | 8 | Value to load |
| count_tick | output | 1 | Single-cycle count-enable pulse |
| count_q | output | 8 | Counter value |

## Verification
The bench counts ticks over windows that are exact multiples of each divided period. A prescaler that wraps at the wrong bit, or taps that are out of phase, would give the wrong count, or give ticks in the wrong cycles against the per-cycle model. It toggles the pin in slow pulses under both edge selects and probes the exact latency. A missing synchronizer stage, the wrong edge polarity, or a detector that stays high would show as shifted, mirrored or doubled ticks. Select changes between fast and stopped rates, a load that coincides with a tick, and a load of 8'hFF followed by a wrap expose a stale tick, a lost write or a counter that saturates.

// File: rtl/tmr_clksel_pkg.sv
package tmr_clksel_pkg;

    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 4;

    typedef enum logic [SEL_W-1:0] {
        CS_STOP     = 3'b000,
        CS_SYS      = 3'b001,
        CS_DIV8     = 3'b010,
        CS_DIV64    = 3'b011,
        CS_DIV256   = 3'b100,
        CS_DIV1024  = 3'b101,
        CS_PIN_FALL = 3'b110,
        CS_PIN_RISE = 3'b111
    } clk_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    // log2 of the division ratio for each prescaler tap
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    // tap index used by a divided select, -1 for all others
    function automatic int sel_to_tap(input clk_sel_e sel);
        case (sel)
            CS_DIV8:    return 0;
            CS_DIV64:   return 1;
            CS_DIV256:  return 2;
            CS_DIV1024: return 3;
            default:    return -1;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_clksel_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    output logic [NUM_TAPS-1:0] tap_hit
);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int SH = tap_shift(g);
        assign tap_hit[g] = (pre_q[SH-1:0] == '0);
    end

    AST_PRE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pre_q == PRE_W'($past(pre_q) + 1'b1));   // R3

    AST_PRE_CLEARED: assert property (@(posedge clk)
        rst |=> pre_q == '0);   // R9

endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge
    import tmr_clksel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_async,
    output pin_edge_t edges
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   level;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level      = sync_q[SYNC_STAGES-1];
    assign edges.rise = level & ~last_q;
    assign edges.fall = ~level & last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        edges.rise |=> !edges.rise);   // R5

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        edges.fall |=> !edges.fall);   // R4

endmodule

// File: rtl/tmr_tick_select.sv
module tmr_tick_select
    import tmr_clksel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  clk_sel_e            sel,
    input  logic [NUM_TAPS-1:0] tap_hit,
    input  pin_edge_t           edges,
    output logic                tick_q
);

    logic tick_d;
    int   tap_idx;

    always_comb begin
        tap_idx = sel_to_tap(sel);
        case (sel)
            CS_STOP:     tick_d = 1'b0;
            CS_SYS:      tick_d = 1'b1;
            CS_PIN_FALL: tick_d = edges.fall;
            CS_PIN_RISE: tick_d = edges.rise;
            default:     tick_d = (tap_idx >= 0) ? tap_hit[tap_idx[1:0]] : 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= tick_d;
    end

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        sel == CS_STOP |=> !tick_q);   // R1

    AST_SYS_EVERY: assert property (@(posedge clk) disable iff (rst)
        sel == CS_SYS |=> tick_q);   // R2

    AST_DIV8_GATED: assert property (@(posedge clk) disable iff (rst)
        (sel == CS_DIV8 && !tap_hit[0]) |=> !tick_q);   // R3

    AST_PIN_RISE_TICK: assert property (@(posedge clk) disable iff (rst)
        (sel == CS_PIN_RISE && edges.rise) |=> tick_q);   // R5

    AST_PIN_FALL_TICK: assert property (@(posedge clk) disable iff (rst)
        (sel == CS_PIN_FALL && edges.fall) |=> tick_q);   // R4

endmodule

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (wr_en) cnt_q <= wr_data;
        else if (tick)  cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));   // R7

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt_q == $past(wr_data));   // R8

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(cnt_q));   // R1

    AST_CNT_RESET: assert property (@(posedge clk)
        rst |=> cnt_q == '0);   // R9

endmodule

// File: rtl/tmr_clock_select.sv
module tmr_clock_select
    import tmr_clksel_pkg::*;
#(
    parameter int PRE_W       = 10,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             ext_pin,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    output logic             count_tick,
    output logic [CNT_W-1:0] count_q
);

    logic [NUM_TAPS-1:0] tap_hit;
    pin_edge_t           edges;
    clk_sel_e            sel;

    assign sel = clk_sel_e'(clk_sel);

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .tap_hit (tap_hit)
    );

    tmr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk       (clk),
        .rst       (rst),
        .pin_async (ext_pin),
        .edges     (edges)
    );

    tmr_tick_select u_sel (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .tap_hit (tap_hit),
        .edges   (edges),
        .tick_q  (count_tick)
    );

    tmr_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (count_tick),
        .wr_en   (cnt_wr_en),
        .wr_data (cnt_wr_data),
        .cnt_q   (count_q)
    );

    AST_TICK_RESET: assert property (@(posedge clk)
        rst |=> !count_tick);   // R9

endmodule

// File: tb/tb_tmr_clock_select.sv
module tb_tmr_clock_select;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] clk_sel = 3'b000;
    logic       ext_pin = 1'b0;
    logic       cnt_wr_en = 1'b0;
    logic [7:0] cnt_wr_data = 8'h00;
    logic       count_tick;
    logic [7:0] count_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    string cur_req = "R9";

    // reference model state
    int m_pre = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0, m_tick = 0, m_cnt = 0;

    tmr_clock_select dut (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .ext_pin(ext_pin),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .count_tick(count_tick), .count_q(count_q)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int period_of(input int sel);
        case (sel)
            2: return 8;
            3: return 64;
            4: return 256;
            5: return 1024;
            default: return 1;
        endcase
    endfunction

    // behavioural model, one step per clock
    always @(posedge clk) begin
        int nt, rise, fall;
        if (rst) begin
            m_pre = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_tick = 0; m_cnt = 0;
        end else begin
            rise = (m_s2 == 1 && m_s3 == 0);
            fall = (m_s2 == 0 && m_s3 == 1);
            case (clk_sel)
                3'd0: nt = 0;
                3'd1: nt = 1;
                3'd6: nt = fall;
                3'd7: nt = rise;
                default: nt = ((m_pre % period_of(int'(clk_sel))) == 0);
            endcase
            if (cnt_wr_en)   m_cnt = int'(cnt_wr_data);
            else if (m_tick) m_cnt = (m_cnt + 1) % 256;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ext_pin);
            m_pre = (m_pre + 1) % 1024;
            m_tick = nt;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({cur_req, " tick vs model"}, int'(count_tick), m_tick);
            chk({cur_req, " count vs model"}, int'(count_q), m_cnt);
        end
    end

    task automatic window(input int n, output int ticks);
        ticks = 0;
        repeat (n) begin
            @(negedge clk);
            ticks += int'(count_tick);
        end
    endtask

    task automatic pin_window(input int pulses, output int ticks);
        ticks = 0;
        for (int p = 0; p < pulses; p++) begin
            ext_pin = 1'b1;
            repeat (3) begin @(negedge clk); ticks += int'(count_tick); end
            ext_pin = 1'b0;
            repeat (3) begin @(negedge clk); ticks += int'(count_tick); end
        end
        repeat (6) begin @(negedge clk); ticks += int'(count_tick); end
    endtask

    initial begin
        int t;
        repeat (3) @(negedge clk);
        chk("R9 reset count", int'(count_q), 0);
        chk("R9 reset tick", int'(count_tick), 0);
        rst = 1'b0;

        cur_req = "R1";
        window(100, t);
        chk("R1 stopped ticks", t, 0);
        chk("R1 count held", int'(count_q), 0);

        cur_req = "R2"; clk_sel = 3'b001;
        window(40, t);
        chk("R2 ticks per cycle", t, 40);

        cur_req = "R3";
        for (int s = 2; s <= 5; s++) begin
            clk_sel = 3'(s);
            window(2 * period_of(s), t);
            chk($sformatf("R3 sel %0d tick count", s), t, 2);
        end

        cur_req = "R4"; clk_sel = 3'b110;
        pin_window(5, t);
        chk("R4 falling-edge ticks", t, 5);

        cur_req = "R5"; clk_sel = 3'b111;
        pin_window(4, t);
        chk("R5 rising-edge ticks", t, 4);

        // latency probe: ticks appear after the third edge
        ext_pin = 1'b1;
        @(negedge clk); chk("R5 no tick after edge 1", int'(count_tick), 0);
        @(negedge clk); chk("R5 no tick after edge 2", int'(count_tick), 0);
        @(negedge clk); chk("R5 tick after edge 3", int'(count_tick), 1);
        @(negedge clk); chk("R5 tick single cycle", int'(count_tick), 0);
        clk_sel = 3'b110; ext_pin = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk); chk("R4 tick after edge 3", int'(count_tick), 1);

        cur_req = "R6"; clk_sel = 3'b101;
        repeat (5) @(negedge clk);
        clk_sel = 3'b001;
        @(negedge clk); chk("R6 fast select next cycle", int'(count_tick), 1);
        clk_sel = 3'b000;
        @(negedge clk); chk("R6 stop select next cycle", int'(count_tick), 0);
        window(20, t);
        chk("R6 no stale ticks", t, 0);

        cur_req = "R8"; clk_sel = 3'b001;
        @(negedge clk);
        cnt_wr_en = 1'b1; cnt_wr_data = 8'hA5;
        @(negedge clk); cnt_wr_en = 1'b0;
        chk("R8 load wins over tick", int'(count_q), 8'hA5);

        cur_req = "R7";
        cnt_wr_en = 1'b1; cnt_wr_data = 8'hFF;
        @(negedge clk); cnt_wr_en = 1'b0;
        chk("R7 loaded FF", int'(count_q), 8'hFF);
        @(negedge clk); chk("R7 wrap to 00", int'(count_q), 0);

        cur_req = "R9"; rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 mid reset count", int'(count_q), 0);
        chk("R9 mid reset tick", int'(count_tick), 0);
        rst = 1'b0; clk_sel = 3'b010;
        window(64, t);
        chk("R3 phase after reset", t, 8);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule